// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store of `DEPTH` words held in a register array, addressed by a stack pointer that wraps modulo the depth. A push first moves the pointer up by one and then writes the incoming word at the new pointer value. A pop first reads the word at the current pointer and then moves the pointer down by one. Two flag registers tell apart the two states in which the pointer is zero. `full` is set when a push wraps the pointer to zero, and `empty` is set when a pop brings the pointer back to zero.

The first word pushed onto an empty stack goes into address 1. The word that fills the stack goes into address 0. An illegal request is refused, and the block raises `err` for one cycle. The illegal requests are a push while full, a pop while empty, and a push and a pop in the same cycle. A refused request leaves the pointer, the flags and the stored words as they were.

Popped data leaves as a one-beat stream. `pop_data` is registered and is qualified by `pop_valid` in the cycle after the request. The output has no back-pressure, so the consumer must take the word in that cycle. The push side has no ready signal either. Before it pushes, a producer checks `full`, and before it pops, it checks `empty`.

Top module: `reg_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `err` is 0 and `pop_valid` is 0.
- R2: A legal push (push_req=1, pop_req=0, full=0) stores `push_data`, and `empty` is 0 in the following cycle.
- R3: A legal pop (pop_req=1, push_req=0, empty=0) returns the most recently pushed word not yet popped. It appears on `pop_data` with `pop_valid`=1 in the cycle after the request. In every other cycle `pop_valid` is 0.
- R4: Starting from empty, `full` stays 0 through the first DEPTH-1 consecutive pushes and becomes 1 after push number DEPTH. The first word is stored at address 1 and the last at address 0.
- R5: `empty` becomes 1 only after the pop that removes the last stored word.
- R6: A push while `full` is 1 raises `err` in the next cycle. It leaves the flags and the stored words unchanged, and `push_data` is not stored.
- R7: A pop while `empty` is 1 raises `err` in the next cycle, keeps `pop_valid` at 0 and leaves the flags unchanged.
- R8: push_req and pop_req both high in one cycle raises `err` in the next cycle, whatever the flags are. It changes nothing: no word is stored, no word is popped, and the flags keep their values.
- R9: `err` is high only in the single cycle after an illegal request. After a legal request or an idle cycle it is 0.
- R10: A legal pop clears `full`, and `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request for this cycle |
| push_data | input | DW (8) | Word to push |
| pop_req | input | 1 | Pop request for this cycle |
| pop_data | output | DW (8) | Popped word, registered |
| pop_valid | output | 1 | pop_data holds a popped word this cycle |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench fills the stack completely and checks that `full` rises on the last of the 64 pushes and not before. If the wrap to address 0 were detected before the write, `full` would rise one push early and one slot would be lost. The bench pushes onto a full stack and then drains every word. If the refused push were not blocked, the slot at address 1 would be overwritten and the last word out would be wrong. The bench also issues a push and a pop together on an empty stack, on a partly filled stack and on a full stack. A design that gave either request priority would change the word count, so the later pops and the flags would disagree with the model.

// File: rtl/reg_stack_pkg.sv
package reg_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import reg_stack_pkg::*;
(
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op
);
  always_comb begin
    op = OP_IDLE;
    if (push_req && pop_req)       op = OP_BAD;
    else if (push_req)             op = full  ? OP_BAD : OP_PUSH;
    else if (pop_req)              op = empty ? OP_BAD : OP_POP;
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import reg_stack_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] sp_dn;

  // pointer arithmetic wraps modulo 2**AW
  assign sp_up = sp + 1'b1;
  assign sp_dn = sp - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          sp    <= sp_up;
          full  <= (sp_up == '0);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_dn;
          empty <= (sp_dn == '0);
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) word_q <= wr_data;
    end
    assign words[g] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= words[rd_addr];
    end
  end
endmodule

// File: rtl/reg_stack.sv
module reg_stack
  import reg_stack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam int AW = $clog2(DEPTH);

  stk_op_e       op;
  logic [AW-1:0] sp, sp_up;

  stk_ctrl u_ctrl (
    .push_req (push_req),
    .pop_req  (pop_req),
    .full     (full),
    .empty    (empty),
    .op       (op)
  );

  stk_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .sp    (sp),
    .sp_up (sp_up),
    .full  (full),
    .empty (empty)
  );

  // push writes at the incremented pointer; pop reads at the current one
  stk_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (op == OP_PUSH),
    .wr_addr  (sp_up),
    .wr_data  (push_data),
    .rd_en    (op == OP_POP),
    .rd_addr  (sp),
    .rd_data  (pop_data),
    .rd_valid (pop_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= (op == OP_BAD);
  end
endmodule

// File: rtl/reg_stack_chk.sv
module reg_stack_chk (
  input logic clk,
  input logic rst_n,
  input logic push_req,
  input logic pop_req,
  input logic pop_valid,
  input logic full,
  input logic empty,
  input logic err
);
  AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> !empty); // R2
  AST_POP_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty) |=> pop_valid); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> (err && full && !empty)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> (err && !pop_valid && empty)); // R7
  AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> (err && !pop_valid && $stable(full) && $stable(empty))); // R8
  AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_req) |=> !err); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty})); // R10
endmodule

bind reg_stack reg_stack_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .pop_valid (pop_valid),
  .full      (full),
  .empty     (empty),
  .err       (err)
);

// File: tb/reg_stack_tb.sv
module reg_stack_tb;
  localparam int DW = 8;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic          pop_valid, full, empty, err;

  int n_run = 0;
  int n_fail = 0;
  int cnt = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  reg_stack #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
    .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; inputs applied, result sampled one cycle later
  task automatic step(input bit p, input bit q, input logic [DW-1:0] d);
    bit bad, lpush, lpop;
    logic [DW-1:0] exp_d;
    string tag;
    bad   = (p && q) || (p && cnt == DEPTH) || (q && cnt == 0);
    lpush = p && !q && cnt < DEPTH;
    lpop  = q && !p && cnt > 0;
    exp_d = lpop ? model[cnt-1] : '0;
    if (bad) tag = (p && q) ? "R8" : (p ? "R6" : "R7");
    else     tag = p ? "R2" : (q ? "R3" : "R9");
    push_req = p; pop_req = q; push_data = d;
    @(negedge clk);
    push_req = 0; pop_req = 0;
    if (lpush) begin model[cnt] = d; cnt++; end
    if (lpop) cnt--;
    chk(err == bad, {tag, " err"}, err, bad);
    chk(pop_valid == lpop, {tag, " pop_valid"}, pop_valid, lpop);
    if (lpop) chk(pop_data == exp_d, "R3 pop_data", pop_data, exp_d);
    chk(full == (cnt == DEPTH), (lpop ? "R10 full" : "R4 full"), full, cnt == DEPTH);
    chk(empty == (cnt == 0), (lpush ? "R2 empty" : "R5 empty"), empty, cnt == 0);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) % 256);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(pop_valid == 1'b0, "R1 pop_valid", pop_valid, 0);

    step(0, 1, 8'h00);          // R7 pop on empty
    step(1, 1, 8'hAA);          // R8 both on empty
    step(0, 0, 8'h00);          // R9 idle

    foreach (model[k]) model[k] = '0;
    for (int r = 0; r < 4; r++) begin
      int k;
      k = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 5 : 17;
      for (int i = 0; i < k; i++) step(1, 0, pat(i + r * 50));
      step(1, 1, 8'h5A);        // R8 both on partial stack
      for (int i = 0; i < k; i++) step(0, 1, 8'h00);
    end

    // R4 fill all slots, full only on the last push
    for (int i = 0; i < DEPTH; i++) step(1, 0, pat(i + 7));
    step(1, 0, 8'hEE);          // R6 push on full
    step(1, 1, 8'hDD);          // R8 both on full
    step(0, 1, 8'h00);          // R10 pop clears full
    step(1, 0, 8'h99);          // refill last slot
    for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00);
    step(0, 1, 8'h00);          // R7 pop on empty after drain
    step(0, 0, 8'h00);

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int s;
      s = (i * 7 + i / 13) % 6;
      step(s < 3 || s == 5, s == 3 || s == 5, pat(i + 100));
    end
    while (cnt > 0) step(0, 1, 8'h00);
    step(0, 0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule